// File: doc/BRIEF.md
# Bit-Banged Serial Memory Protocol Decoder

This block recovers a serial memory protocol that software drives one written byte at a time into a single control register. Each byte carries the states of the clock and data lines. Clock edges are not sampled. Instead, the decoder keeps the four most recent bytes. It compares that history plus the incoming byte against fixed patterns that stand for start, clock (sync or read step), bit zero and bit one.

Written bits are gathered LSB first into an 8-bit word. In the address phase a finished word selects one of 128 byte locations. In the data phase a finished word is stored at the selected location. Read steps return the stored byte one bit at a time, LSB first, on bit 4 of a status output. That output is OR-ed with an external status byte supplied by the surrounding logic.

Top module: `eep_bb_decoder`

## Requirements
- R1: After reset the following all read zero: the status flag, the phase (address), the address, both bit pointers, the assembled word and the four-byte history.
- R2: Each accepted write shifts the history by one place, and the new byte becomes the newest entry. Without a write, no state changes.
- R3: Writing 0x80 clears the address, the phase and both bit pointers. This takes priority over every other pattern.
- R4: Start is a new byte of 0x00 arriving on a history of 0x00, 0x40, 0x60, 0x20 (oldest first). It sets both pointers to 0x01, clears the assembled word and selects the address phase.
- R5: Clock is a new byte of 0xE0 arriving when the newest history byte is 0x60. In the address phase it acts as sync: it selects the data phase, sets both pointers to 0x01, clears the word and clears the status flag.
- R6: Clock in the data phase acts as a read step. It loads the word from storage at the current address. The status flag becomes 1 when the loaded byte ANDed with the read pointer is nonzero, and 0 otherwise. The read pointer then shifts left and the write pointer clears.
- R7: Bit-zero is a new byte of 0x00 arriving on a history ending 0x00, 0x20. Bit-one is a new byte of 0x00 arriving on a history of 0x00, 0x40, 0x60, 0x40. Each clears or sets the word bit selected by the write pointer, and each clears the read pointer.
- R8: The write pointer advances left from 0x01. A bit taken while the pointer is 0x80 completes the word. In the address phase the low 7 bits of the word become the address. In the data phase the word is stored at the address. In both phases the write pointer then clears.
- R9: status_o equals ext_status_i with bit 4 OR-ed with the status flag. The flag updates on the clock edge that accepts the write.
- R10: The 128 x 8 storage resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Byte written to the control register |
| ext_status_i | input | 8 | External status bits merged into the output |
| status_o | output | 8 | Status byte; bit 4 carries the read bit |

## Verification
The following properties are checked on every cycle:
- the clearing effect of 0x80;
- the pointer values after start, sync and bit patterns;
- that both pointers stay one-hot or zero;
- that no state moves without a write;
- that the non-flag status bits follow the external input.

Full multi-byte transactions can only be shown by the bench's scenarios:
- storing a word at an address assembled LSB first, then reading it back bit by bit;
- reads from locations that were never written;
- patterns that come close to a command but do not match one.

// File: rtl/eep_bb_pkg.sv
package eep_bb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HIST_LEN = 4;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t LV_IDLE  = 8'h00;
  localparam byte_t LV_DLO   = 8'h20;
  localparam byte_t LV_DHI   = 8'h40;
  localparam byte_t LV_CLKHI = 8'h60;
  localparam byte_t LV_READ  = 8'hE0;
  localparam byte_t LV_CLEAR = 8'h80;
  localparam int unsigned FLAG_BIT = 4;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_CLEAR, CMD_START, CMD_CLOCK, CMD_BIT0, CMD_BIT1
  } cmd_e;
endpackage

// File: rtl/eep_bb_hist.sv
module eep_bb_hist
  import eep_bb_pkg::*;
#(
  parameter int unsigned DEPTH = HIST_LEN
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  byte_t                        wr_data_i,
  output logic [DEPTH-1:0][BYTE_W-1:0] hist_o   // [0] newest
);
  logic [DEPTH-1:0][BYTE_W-1:0] hist_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[i] <= '0;
      else if (wr_en_i) begin
        if (i == 0) hist_q[i] <= wr_data_i;
        else        hist_q[i] <= hist_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/eep_bb_match.sv
module eep_bb_match
  import eep_bb_pkg::*;
(
  input  logic                            wr_en_i,
  input  byte_t                           wr_data_i,
  input  logic [HIST_LEN-1:0][BYTE_W-1:0] hist_i,
  output cmd_e                            cmd_o
);
  logic is_clear, is_start, is_clock, is_bit0, is_bit1, lo_new;

  assign lo_new   = (wr_data_i == LV_IDLE);
  assign is_clear = (wr_data_i == LV_CLEAR);
  assign is_start = lo_new && hist_i[3] == LV_IDLE && hist_i[2] == LV_DHI &&
                    hist_i[1] == LV_CLKHI && hist_i[0] == LV_DLO;
  assign is_clock = (wr_data_i == LV_READ) && hist_i[0] == LV_CLKHI;
  assign is_bit0  = lo_new && hist_i[1] == LV_IDLE && hist_i[0] == LV_DLO;
  assign is_bit1  = lo_new && hist_i[3] == LV_IDLE && hist_i[2] == LV_DHI &&
                    hist_i[1] == LV_CLKHI && hist_i[0] == LV_DHI;

  // priority: clear, start, clock, bit0, bit1
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_en_i) begin
      if (is_clear)      cmd_o = CMD_CLEAR;
      else if (is_start) cmd_o = CMD_START;
      else if (is_clock) cmd_o = CMD_CLOCK;
      else if (is_bit0)  cmd_o = CMD_BIT0;
      else if (is_bit1)  cmd_o = CMD_BIT1;
    end
  end
endmodule

// File: rtl/eep_bb_store.sv
module eep_bb_store
  import eep_bb_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  output byte_t         rdata_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eep_bb_engine.sv
module eep_bb_engine
  import eep_bb_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  byte_t         mem_rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          mode_o,     // 0 address phase, 1 data phase
  output byte_t         wbit_o,
  output byte_t         rbit_o,
  output logic          flag_o,
  output logic          mem_we_o,
  output byte_t         mem_wdata_o
);
  logic [AW-1:0] addr_q, addr_n;
  logic          mode_q, mode_n, flag_q, flag_n;
  byte_t         wbit_q, wbit_n, rbit_q, rbit_n, data_q, data_n;
  logic          bit_cmd;

  assign bit_cmd = (cmd_i == CMD_BIT0) || (cmd_i == CMD_BIT1);

  always_comb begin
    addr_n = addr_q;
    mode_n = mode_q;
    flag_n = flag_q;
    wbit_n = wbit_q;
    rbit_n = rbit_q;
    data_n = data_q;
    unique case (cmd_i)
      CMD_CLEAR: begin
        addr_n = '0;
        mode_n = 1'b0;
        wbit_n = '0;
        rbit_n = '0;
      end
      CMD_START: begin
        wbit_n = 8'h01;
        rbit_n = 8'h01;
        data_n = '0;
        mode_n = 1'b0;
      end
      CMD_CLOCK: begin
        if (!mode_q) begin
          mode_n = 1'b1;
          wbit_n = 8'h01;
          rbit_n = 8'h01;
          data_n = '0;
          flag_n = 1'b0;
        end else begin
          data_n = mem_rdata_i;
          flag_n = |(mem_rdata_i & rbit_q);
          rbit_n = rbit_q << 1;
          wbit_n = '0;
        end
      end
      CMD_BIT0, CMD_BIT1: begin
        data_n = (cmd_i == CMD_BIT1) ? (data_q | wbit_q) : (data_q & ~wbit_q);
        if (wbit_q[BYTE_W-1]) begin
          if (!mode_q) addr_n = data_n[AW-1:0];
          wbit_n = '0;
        end else begin
          wbit_n = wbit_q << 1;
        end
        rbit_n = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mode_q <= 1'b0;
      flag_q <= 1'b0;
      wbit_q <= '0;
      rbit_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_n;
      mode_q <= mode_n;
      flag_q <= flag_n;
      wbit_q <= wbit_n;
      rbit_q <= rbit_n;
      data_q <= data_n;
    end
  end

  assign mem_we_o    = bit_cmd && wbit_q[BYTE_W-1] && mode_q;
  assign mem_wdata_o = data_n;
  assign addr_o      = addr_q;
  assign mode_o      = mode_q;
  assign wbit_o      = wbit_q;
  assign rbit_o      = rbit_q;
  assign flag_o      = flag_q;
endmodule

// File: rtl/eep_bb_decoder.sv
module eep_bb_decoder
  import eep_bb_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] ext_status_i,
  output logic [7:0] status_o
);
  logic [HIST_LEN-1:0][BYTE_W-1:0] hist;
  cmd_e          cmd;
  logic [AW-1:0] addr_q;
  logic          mode_q, flag_q, mem_we;
  byte_t         wbit_q, rbit_q, mem_rdata, mem_wdata;

  eep_bb_hist #(.DEPTH(HIST_LEN)) u_hist (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .hist_o(hist)
  );

  eep_bb_match u_match (
    .wr_en_i, .wr_data_i, .hist_i(hist), .cmd_o(cmd)
  );

  eep_bb_engine #(.AW(AW)) u_engine (
    .clk_i, .rst_ni, .cmd_i(cmd), .mem_rdata_i(mem_rdata),
    .addr_o(addr_q), .mode_o(mode_q), .wbit_o(wbit_q), .rbit_o(rbit_q),
    .flag_o(flag_q), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  eep_bb_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .we_i(mem_we), .addr_i(addr_q),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  assign status_o = ext_status_i | (byte_t'(flag_q) << FLAG_BIT);
endmodule

// File: rtl/eep_bb_checker.sv
module eep_bb_checker
  import eep_bb_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic [7:0]                      wr_data_i,
  input logic [7:0]                      ext_status_i,
  input logic [7:0]                      status_o,
  input logic [HIST_LEN-1:0][BYTE_W-1:0] hist,
  input logic [AW-1:0]                   addr_q,
  input logic                            mode_q,
  input logic                            flag_q,
  input logic [7:0]                      wbit_q,
  input logic [7:0]                      rbit_q
);
  localparam byte_t FMASK = byte_t'(1) << FLAG_BIT;

  assert_ext_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~FMASK) == (ext_status_i & ~FMASK));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == LV_CLEAR |=>
      addr_q == '0 && !mode_q && wbit_q == '0 && rbit_q == '0);

  assert_ptr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wbit_q) && $onehot0(rbit_q));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(addr_q) && $stable(mode_q) && $stable(wbit_q) &&
                 $stable(rbit_q) && $stable(flag_q) && $stable(hist));

  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == LV_IDLE && hist[3] == LV_IDLE && hist[2] == LV_DHI &&
    hist[1] == LV_CLKHI && hist[0] == LV_DLO |=>
      wbit_q == 8'h01 && rbit_q == 8'h01 && !mode_q);

  assert_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == LV_READ && hist[0] == LV_CLKHI && !mode_q |=>
      mode_q && wbit_q == 8'h01 && rbit_q == 8'h01 && !flag_q);

  assert_bit0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == LV_IDLE && hist[1] == LV_IDLE && hist[0] == LV_DLO |=>
      rbit_q == '0);
endmodule

bind eep_bb_decoder eep_bb_checker #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .ext_status_i, .status_o,
  .hist, .addr_q, .mode_q, .flag_q, .wbit_q, .rbit_q
);

// File: tb/eep_bb_decoder_test.sv
module eep_bb_decoder_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] ext_status_i = '0;
  logic [7:0] status_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [7:0] m_hist [4];
  logic [6:0] m_addr;
  logic       m_mode, m_flag;
  logic [7:0] m_wbit, m_rbit, m_data;
  logic [7:0] m_mem [128];

  always #4 clk = ~clk;

  eep_bb_decoder uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .ext_status_i, .status_o
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: status_o=%02h expected %02h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) m_hist[i] = '0;
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    m_addr = '0; m_mode = 0; m_flag = 0;
    m_wbit = '0; m_rbit = '0; m_data = '0;
  endfunction

  function automatic void model_write(logic [7:0] d);
    bit st, ck, b0, b1;
    st = d == 8'h00 && m_hist[3] == 8'h00 && m_hist[2] == 8'h40 &&
         m_hist[1] == 8'h60 && m_hist[0] == 8'h20;
    ck = d == 8'hE0 && m_hist[0] == 8'h60;
    b0 = d == 8'h00 && m_hist[1] == 8'h00 && m_hist[0] == 8'h20;
    b1 = d == 8'h00 && m_hist[3] == 8'h00 && m_hist[2] == 8'h40 &&
         m_hist[1] == 8'h60 && m_hist[0] == 8'h40;
    if (d == 8'h80) begin
      m_addr = '0; m_mode = 0; m_wbit = '0; m_rbit = '0;
    end else if (st) begin
      m_wbit = 8'h01; m_rbit = 8'h01; m_data = '0; m_mode = 0;
    end else if (ck) begin
      if (!m_mode) begin
        m_mode = 1; m_wbit = 8'h01; m_rbit = 8'h01; m_data = '0; m_flag = 0;
      end else begin
        m_data = m_mem[m_addr];
        m_flag = (m_data & m_rbit) != 0;
        m_rbit = m_rbit << 1; m_wbit = '0;
      end
    end else if (b0 || b1) begin
      if (b1) m_data = m_data | m_wbit;
      else    m_data = m_data & ~m_wbit;
      if (m_wbit == 8'h80) begin
        if (m_mode) m_mem[m_addr] = m_data;
        else        m_addr = m_data[6:0];
        m_wbit = '0;
      end else m_wbit = m_wbit << 1;
      m_rbit = '0;
    end
    m_hist[3] = m_hist[2]; m_hist[2] = m_hist[1];
    m_hist[1] = m_hist[0]; m_hist[0] = d;
  endfunction

  task automatic put(logic [7:0] d, string req);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    ext_status_i = 8'($urandom) & 8'hEF;
    model_write(d);
    @(negedge clk);
    wr_en_i = 1'b0;
    check(req, status_o, ext_status_i | {3'b0, m_flag, 4'b0});
  endtask

  task automatic seq_start(string req);
    put(8'h00, req); put(8'h40, req); put(8'h60, req); put(8'h20, req); put(8'h00, req);
  endtask
  task automatic seq_bit(bit v, string req);
    if (v) begin
      put(8'h00, req); put(8'h40, req); put(8'h60, req); put(8'h40, req); put(8'h00, req);
    end else begin
      put(8'h00, req); put(8'h20, req); put(8'h00, req);
    end
  endtask
  task automatic seq_clock(string req);
    put(8'h60, req); put(8'hE0, req);
  endtask
  task automatic seq_byte(logic [7:0] v, string req);
    for (int i = 0; i < 8; i++) seq_bit(v[i], req);  // LSB first
  endtask

  initial begin
    process::self().srandom(32'd1729);
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset", status_o, 8'h00);
    ext_status_i = 8'h0F;
    #1 check("R9 ext merge", status_o, 8'h0F);

    // R10: read untouched location 0x33 bit by bit
    seq_start("R4 start");
    seq_byte(8'h33, "R8 addr");
    seq_clock("R5 sync");
    for (int i = 0; i < 8; i++) seq_clock("R10 zero read");

    // R8: store 0xA5 at 0x12, then read back (R6)
    seq_start("R4 start");
    seq_byte(8'h12, "R8 addr");
    seq_clock("R5 sync");
    seq_byte(8'hA5, "R8 store");
    seq_start("R4 start");
    seq_byte(8'h12, "R8 addr");
    seq_clock("R5 sync");
    for (int i = 0; i < 10; i++) seq_clock("R6 read");

    // R3: clear wins; after clear a clock is a sync again
    put(8'h80, "R3 clear");
    seq_clock("R3 sync after clear");
    seq_clock("R6 read addr0");

    // R2: idle cycles and near-miss patterns change nothing
    repeat (5) @(negedge clk);
    check("R2 idle", status_o, ext_status_i | {3'b0, m_flag, 4'b0});
    put(8'h20, "R2 near"); put(8'hE0, "R2 near"); put(8'h40, "R7 near");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned k = $urandom_range(0, 9);
      case (k)
        0: seq_start("R4 rand");
        1, 2: seq_bit(1'b0, "R7 rand");
        3, 4: seq_bit(1'b1, "R7 rand");
        5, 6: seq_clock("R6 rand");
        7: if ($urandom_range(0, 7) == 0) put(8'h80, "R3 rand");
        8: begin
          logic [7:0] v;
          v = {$urandom_range(0, 7), 5'b0};
          put(v, "R2 rand");
        end
        default: begin
          seq_start("R8 rand");
          seq_byte(8'($urandom), "R8 rand");
          seq_clock("R5 rand");
        end
      endcase
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule